// File: doc/BRIEF.md
# Register Rename Unit with Undo History

This block translates architectural register numbers into physical register numbers for an out-of-order core. It handles one instruction per cycle. A map table gives the current physical register for each architectural register. A first-in first-out pool of spare physical registers supplies fresh destinations. An ordered history buffer logs every rename, so a mispredicted path can be rolled back and finished work can release its old registers.

The front end offers an instruction with a sequence number, two source indices and an optional destination. It gets back the physical sources, the newly allocated physical destination and the physical register that destination replaced. An instruction without a destination still takes a history slot, as a placeholder that holds only its sequence number.

A completion input names the highest finished sequence number. Entries at or below it leave the oldest end of the history, one per cycle. A flush input names the last surviving sequence number. Entries above it are unwound from the newest end, one per cycle, and the stall output stays high until the unwind is over. Six event counters report renaming and recovery activity.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The spare pool holds physical registers NUM_ARCH up to NUM_PHYS-1 in ascending order. The history is empty, stall is low with no request pending, and every counter reads zero.
- R2: Each physical source output equals the map table entry for its source index at that moment. It is combinational and does not depend on req_valid.
- R3: An accepted request with a destination shows the head of the spare pool on dst_phys_new and the destination's current mapping on dst_phys_prev. From the next cycle the map points to the new register. That register leaves the head of the pool, and returned registers join its tail.
- R4: An accepted request without a destination adds a placeholder to the history and changes neither the map nor the spare pool.
- R5: A flush with sequence S removes history entries from the newest end, one per cycle starting the cycle after the flush, while their sequence number is greater than S (unsigned, no wrap). A removed non-placeholder entry restores its architectural register to the previous physical register and puts the new physical register at the pool tail.
- R6: stall is high in the flush cycle and while the unwind runs, for k+1 cycles after the flush cycle when k entries are removed. No request is accepted during this time. A completion presented in the same cycle as a flush is ignored.
- R7: A completion with sequence D removes, one per cycle, every oldest history entry whose sequence number is at or below D. Each removed non-placeholder entry puts its previous physical register at the pool tail.
- R8: A request with a destination while the pool is empty raises stall and is not accepted. A request without a destination is still accepted if the history has room.
- R9: A request of either kind while the history holds HB_DEPTH entries raises stall and is not accepted.
- R10: The counters count, in turn: destinations renamed; source lookups (NUM_SRC per accepted request); placeholders added; non-placeholder entries retired by completion; entries removed by flush; and those removed by flush that were not placeholders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Rename request present |
| req_seq | input | SEQ_W | Sequence number of the request |
| req_src_arch | input | NUM_SRC*ARCH_W | Source architectural indices, source 0 in the low bits |
| req_dst_valid | input | 1 | Request has a destination |
| req_dst_arch | input | ARCH_W | Destination architectural index |
| commit_valid | input | 1 | Completion indication |
| commit_seq | input | SEQ_W | Highest completed sequence number |
| squash_valid | input | 1 | Flush indication |
| squash_seq | input | SEQ_W | Newest surviving sequence number |
| rename_ack | output | 1 | Request accepted this cycle |
| stall | output | 1 | Request cannot be accepted |
| src_phys | output | NUM_SRC*PHYS_W | Physical sources, source 0 in the low bits |
| dst_phys_new | output | PHYS_W | Newly allocated physical destination |
| dst_phys_prev | output | PHYS_W | Physical register the destination replaces |
| cnt_dst_renames | output | CNT_W | Destinations renamed |
| cnt_src_lookups | output | CNT_W | Source lookups made |
| cnt_placeholders | output | CNT_W | Placeholders added |
| cnt_commit_maps | output | CNT_W | Non-placeholder entries retired |
| cnt_undo_maps | output | CNT_W | Entries removed by flush |
| cnt_undo_live | output | CNT_W | Non-placeholder entries removed by flush |

## Verification
The bench builds the block with 32 architectural registers, 48 physical registers and a 24-entry history, so only 16 spare registers exist. With these sizes the pool runs dry while the history still has room, and placeholders can then fill the history to its limit. That makes the empty-pool and full-history stalls two separate, observable conditions. Flushes that unwind anything from zero entries to the whole history, and completions that interleave with them, are mixed with directed cases. The cases include a flush and a completion in the same cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;

   // source of the register returned to the spare pool in a cycle
   typedef enum logic [1:0] {
      RET_NONE   = 2'd0,
      RET_UNDO   = 2'd1,
      RET_COMMIT = 2'd2
   } ret_src_e;

   // pointer width that never collapses to zero bits
   function automatic int ptr_width(input int depth);
      return (depth > 2) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   parameter int NUM_SRC  = 2,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int PW = $clog2(NUM_PHYS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SRC-1:0][AW-1:0]    rd_arch,
   output logic [NUM_SRC-1:0][PW-1:0]    rd_phys,
   input  logic [AW-1:0]                 dst_arch,
   output logic [PW-1:0]                 dst_phys,
   input  logic                          wr_en,
   input  logic [AW-1:0]                 wr_arch,
   input  logic [PW-1:0]                 wr_phys
);

   logic [PW-1:0] map_q [NUM_ARCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
      end else if (wr_en) begin
         map_q[wr_arch] <= wr_phys;
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_rd
      assign rd_phys[g] = map_q[rd_arch[g]];
   end

   assign dst_phys = map_q[dst_arch];

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   localparam int PW    = $clog2(NUM_PHYS),
   localparam int DEPTH = NUM_PHYS - NUM_ARCH,
   localparam int PTR_W = rn_pkg::ptr_width(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          push,
   input  logic [PW-1:0] push_phys,
   output logic [PW-1:0] head_phys,
   output logic          empty
);

   logic [PW-1:0]    slot_q [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [CW-1:0]    cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= PW'(NUM_ARCH + i);
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= CW'(DEPTH);
      end else begin
         if (push) begin
            slot_q[wr_q] <= push_phys;
            wr_q         <= bump(wr_q);
         end
         if (pop) rd_q <= bump(rd_q);
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   assign head_phys = slot_q[rd_q];
   assign empty     = (cnt_q == '0);

   // R8: an allocation never takes from an empty pool
   a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0);

   // R3: a returned register always finds a free slot
   a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> cnt_q != CW'(DEPTH));

endmodule

// File: rtl/rn_history_buf.sv
module rn_history_buf #(
   parameter int DEPTH = 32,
   parameter int SEQ_W = 16,
   parameter int AW    = 5,
   parameter int PW    = 6,
   localparam int PTR_W = rn_pkg::ptr_width(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             push_ph,
   input  logic [SEQ_W-1:0] push_seq,
   input  logic [AW-1:0]    push_arch,
   input  logic [PW-1:0]    push_new,
   input  logic [PW-1:0]    push_prev,
   input  logic             pop_old,
   input  logic             pop_new,
   output logic             old_ph,
   output logic [SEQ_W-1:0] old_seq,
   output logic [PW-1:0]    old_prev,
   output logic             new_ph,
   output logic [SEQ_W-1:0] new_seq,
   output logic [AW-1:0]    new_arch,
   output logic [PW-1:0]    new_new,
   output logic [PW-1:0]    new_prev,
   output logic             empty,
   output logic             full
);

   typedef struct packed {
      logic             ph;
      logic [SEQ_W-1:0] seq;
      logic [AW-1:0]    arch;
      logic [PW-1:0]    pnew;
      logic [PW-1:0]    pprev;
   } ent_t;

   ent_t             mem_q [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q, last_idx;
   logic [CW-1:0]    cnt_q;
   ent_t             old_e, new_e;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign last_idx = (tail_q == '0) ? PTR_W'(DEPTH - 1) : tail_q - 1'b1;

   always_ff @(posedge clk) begin
      if (push) mem_q[tail_q] <= '{ph: push_ph, seq: push_seq, arch: push_arch,
                                   pnew: push_new, pprev: push_prev};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push)    tail_q <= bump(tail_q);
         if (pop_new) tail_q <= last_idx;
         if (pop_old) head_q <= bump(head_q);
         cnt_q <= cnt_q + CW'(push) - CW'(pop_old) - CW'(pop_new);
      end
   end

   assign old_e    = mem_q[head_q];
   assign new_e    = mem_q[last_idx];
   assign old_ph   = old_e.ph;
   assign old_seq  = old_e.seq;
   assign old_prev = old_e.pprev;
   assign new_ph   = new_e.ph;
   assign new_seq  = new_e.seq;
   assign new_arch = new_e.arch;
   assign new_new  = new_e.pnew;
   assign new_prev = new_e.pprev;
   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == CW'(DEPTH));

   // R9: no entry is written into a full history
   a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> cnt_q != CW'(DEPTH));

   // R5: the unwind only takes entries that exist and never races a rename
   a_r5_undo_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pop_new |-> (cnt_q != '0) && !push && !pop_old);

   // R7: retirement only takes entries that exist
   a_r7_retire_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pop_old |-> cnt_q != '0);

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   parameter int HB_DEPTH = 32,
   parameter int NUM_SRC  = 2,
   parameter int SEQ_W    = 16,
   parameter int CNT_W    = 16,
   localparam int ARCH_W  = $clog2(NUM_ARCH),
   localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [SEQ_W-1:0]           req_seq,
   input  logic [NUM_SRC*ARCH_W-1:0]  req_src_arch,
   input  logic                       req_dst_valid,
   input  logic [ARCH_W-1:0]          req_dst_arch,
   input  logic                       commit_valid,
   input  logic [SEQ_W-1:0]           commit_seq,
   input  logic                       squash_valid,
   input  logic [SEQ_W-1:0]           squash_seq,
   output logic                       rename_ack,
   output logic                       stall,
   output logic [NUM_SRC*PHYS_W-1:0]  src_phys,
   output logic [PHYS_W-1:0]          dst_phys_new,
   output logic [PHYS_W-1:0]          dst_phys_prev,
   output logic [CNT_W-1:0]           cnt_dst_renames,
   output logic [CNT_W-1:0]           cnt_src_lookups,
   output logic [CNT_W-1:0]           cnt_placeholders,
   output logic [CNT_W-1:0]           cnt_commit_maps,
   output logic [CNT_W-1:0]           cnt_undo_maps,
   output logic [CNT_W-1:0]           cnt_undo_live
);
   import rn_pkg::*;

   // elaboration-time parameter checks
   if (NUM_PHYS <= NUM_ARCH + 1) begin : g_chk_phys
      $error("reg_rename: NUM_PHYS must exceed NUM_ARCH by at least two");
   end
   if (NUM_ARCH != (1 << ARCH_W) || NUM_ARCH < 2) begin : g_chk_arch
      $error("reg_rename: NUM_ARCH must be a power of two");
   end
   if (HB_DEPTH < 2) begin : g_chk_hb
      $error("reg_rename: HB_DEPTH must be at least two");
   end
   if (NUM_SRC < 1) begin : g_chk_src
      $error("reg_rename: NUM_SRC must be at least one");
   end

   // recovery and retirement state
   logic             undo_q;
   logic [SEQ_W-1:0] undo_tgt_q;
   logic             done_seen_q;
   logic [SEQ_W-1:0] done_tgt_q;

   // history buffer view
   logic             hb_empty, hb_full;
   logic             hb_old_ph, hb_new_ph;
   logic [SEQ_W-1:0] hb_old_seq, hb_new_seq;
   logic [PHYS_W-1:0] hb_old_prev, hb_new_new, hb_new_prev;
   logic [ARCH_W-1:0] hb_new_arch;

   // free pool view
   logic              fl_empty, fl_push;
   logic [PHYS_W-1:0] fl_head, fl_push_phys;
   ret_src_e          ret_sel;

   // map write port
   logic              map_wr;
   logic [ARCH_W-1:0] map_wr_arch;
   logic [PHYS_W-1:0] map_wr_phys;

   logic undo_hit, retire_hit, alloc;

   assign undo_hit   = undo_q && !hb_empty && (hb_new_seq > undo_tgt_q);
   assign retire_hit = !undo_q && !squash_valid && done_seen_q && !hb_empty &&
                       (hb_old_seq <= done_tgt_q);

   assign stall      = squash_valid || undo_q ||
                       (req_valid && (hb_full || (req_dst_valid && fl_empty)));
   assign rename_ack = req_valid && !stall;
   assign alloc      = rename_ack && req_dst_valid;

   // one register at most returns to the pool per cycle
   always_comb begin
      ret_sel = RET_NONE;
      if (undo_hit && !hb_new_ph)          ret_sel = RET_UNDO;
      else if (retire_hit && !hb_old_ph)   ret_sel = RET_COMMIT;
   end

   always_comb begin
      fl_push      = 1'b0;
      fl_push_phys = '0;
      unique case (ret_sel)
         RET_UNDO:   begin fl_push = 1'b1; fl_push_phys = hb_new_new;  end
         RET_COMMIT: begin fl_push = 1'b1; fl_push_phys = hb_old_prev; end
         default:    ;
      endcase
   end

   // unwinding restores the map; otherwise a new destination writes it
   always_comb begin
      map_wr      = 1'b0;
      map_wr_arch = req_dst_arch;
      map_wr_phys = fl_head;
      if (undo_hit) begin
         map_wr      = !hb_new_ph;
         map_wr_arch = hb_new_arch;
         map_wr_phys = hb_new_prev;
      end else if (alloc) begin
         map_wr      = 1'b1;
      end
   end

   rn_map_table #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS),
      .NUM_SRC  (NUM_SRC)
   ) map_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_arch  (req_src_arch),
      .rd_phys  (src_phys),
      .dst_arch (req_dst_arch),
      .dst_phys (dst_phys_prev),
      .wr_en    (map_wr),
      .wr_arch  (map_wr_arch),
      .wr_phys  (map_wr_phys)
   );

   rn_free_list #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS)
   ) pool_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (alloc),
      .push      (fl_push),
      .push_phys (fl_push_phys),
      .head_phys (fl_head),
      .empty     (fl_empty)
   );

   rn_history_buf #(
      .DEPTH (HB_DEPTH),
      .SEQ_W (SEQ_W),
      .AW    (ARCH_W),
      .PW    (PHYS_W)
   ) hist_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rename_ack),
      .push_ph   (!req_dst_valid),
      .push_seq  (req_seq),
      .push_arch (req_dst_arch),
      .push_new  (fl_head),
      .push_prev (dst_phys_prev),
      .pop_old   (retire_hit),
      .pop_new   (undo_hit),
      .old_ph    (hb_old_ph),
      .old_seq   (hb_old_seq),
      .old_prev  (hb_old_prev),
      .new_ph    (hb_new_ph),
      .new_seq   (hb_new_seq),
      .new_arch  (hb_new_arch),
      .new_new   (hb_new_new),
      .new_prev  (hb_new_prev),
      .empty     (hb_empty),
      .full      (hb_full)
   );

   assign dst_phys_new = fl_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         undo_q      <= 1'b0;
         undo_tgt_q  <= '0;
         done_seen_q <= 1'b0;
         done_tgt_q  <= '0;
      end else begin
         if (squash_valid) begin
            undo_q     <= 1'b1;
            undo_tgt_q <= squash_seq;
         end else if (undo_q && !undo_hit) begin
            undo_q     <= 1'b0;
         end
         if (commit_valid && !squash_valid) begin
            done_seen_q <= 1'b1;
            done_tgt_q  <= commit_seq;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_dst_renames  <= '0;
         cnt_src_lookups  <= '0;
         cnt_placeholders <= '0;
         cnt_commit_maps  <= '0;
         cnt_undo_maps    <= '0;
         cnt_undo_live    <= '0;
      end else begin
         if (alloc)                        cnt_dst_renames  <= cnt_dst_renames + 1'b1;
         if (rename_ack)                   cnt_src_lookups  <= cnt_src_lookups + CNT_W'(NUM_SRC);
         if (rename_ack && !req_dst_valid) cnt_placeholders <= cnt_placeholders + 1'b1;
         if (retire_hit && !hb_old_ph)     cnt_commit_maps  <= cnt_commit_maps + 1'b1;
         if (undo_hit)                     cnt_undo_maps    <= cnt_undo_maps + 1'b1;
         if (undo_hit && !hb_new_ph)       cnt_undo_live    <= cnt_undo_live + 1'b1;
      end
   end

   // R6: a flush always starts an unwind in the following cycle
   a_r6_flush_starts_unwind: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> undo_q);

   // R5: when the unwind ends, no entry newer than the target is left
   a_r5_unwind_complete: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(undo_q) |-> (hb_empty || (hb_new_seq <= undo_tgt_q)));

   // R6: nothing is accepted while recovery is pending
   a_r6_no_ack_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      $past(squash_valid) |-> !rename_ack);

endmodule

// File: tb/reg_rename_tb_top.sv
module reg_rename_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NA    = 32;
   localparam int NP    = 48;
   localparam int HBD   = 24;
   localparam int NS    = 2;
   localparam int SW    = 16;
   localparam int CW    = 16;
   localparam int AW    = $clog2(NA);
   localparam int PW    = $clog2(NP);
   localparam int NFREE = NP - NA;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [SW-1:0]     req_seq = '0;
   logic [NS*AW-1:0]  req_src_arch = '0;
   logic              req_dst_valid = 1'b0;
   logic [AW-1:0]     req_dst_arch = '0;
   logic              commit_valid = 1'b0;
   logic [SW-1:0]     commit_seq = '0;
   logic              squash_valid = 1'b0;
   logic [SW-1:0]     squash_seq = '0;
   logic              rename_ack, stall;
   logic [NS*PW-1:0]  src_phys;
   logic [PW-1:0]     dst_phys_new, dst_phys_prev;
   logic [CW-1:0]     c_dst, c_look, c_ph, c_com, c_und, c_live;

   always #(CLK_PERIOD/2) clk = ~clk;

   reg_rename #(
      .NUM_ARCH (NA), .NUM_PHYS (NP), .HB_DEPTH (HBD),
      .NUM_SRC (NS), .SEQ_W (SW), .CNT_W (CW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_seq (req_seq), .req_src_arch (req_src_arch),
      .req_dst_valid (req_dst_valid), .req_dst_arch (req_dst_arch),
      .commit_valid (commit_valid), .commit_seq (commit_seq),
      .squash_valid (squash_valid), .squash_seq (squash_seq),
      .rename_ack (rename_ack), .stall (stall), .src_phys (src_phys),
      .dst_phys_new (dst_phys_new), .dst_phys_prev (dst_phys_prev),
      .cnt_dst_renames (c_dst), .cnt_src_lookups (c_look),
      .cnt_placeholders (c_ph), .cnt_commit_maps (c_com),
      .cnt_undo_maps (c_und), .cnt_undo_live (c_live)
   );

   // reference model
   typedef struct { int ph; int seq; int arch; int pnew; int pprev; } hent_t;
   int    map_m [NA];
   int    pool_m [$];
   hent_t hist_m [$];
   int    m_dst, m_look, m_ph, m_com, m_und, m_live;
   int    seq_n = 1;
   int    checks = 0, errors = 0;
   bit    finished = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int src_of(input int k);
      return int'(src_phys[k*PW +: PW]);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NA; i++) map_m[i] = i;
      pool_m.delete();
      for (int i = 0; i < NFREE; i++) pool_m.push_back(NA + i);
      hist_m.delete();
      m_dst = 0; m_look = 0; m_ph = 0; m_com = 0; m_und = 0; m_live = 0;
   endtask

   // starts and ends at a falling edge
   task automatic do_rename(input int s0, input int s1, input bit dv, input int d);
      bit exp_stall;
      req_valid     = 1'b1;
      req_seq       = SW'(seq_n);
      req_src_arch  = {AW'(s1), AW'(s0)};
      req_dst_valid = dv;
      req_dst_arch  = AW'(d);
      #1;
      exp_stall = (hist_m.size() == HBD) || (dv && pool_m.size() == 0);
      chk(dv ? "R8 stall on request" : "R9 stall on request", int'(stall), int'(exp_stall));
      chk("R6 ack", int'(rename_ack), int'(!exp_stall));
      chk("R2 src0 lookup", src_of(0), map_m[s0]);
      chk("R2 src1 lookup", src_of(1), map_m[s1]);
      if (!exp_stall && dv) begin
         chk("R3 new phys from pool head", int'(dst_phys_new), pool_m[0]);
         chk("R3 prev phys from map", int'(dst_phys_prev), map_m[d]);
      end
      @(posedge clk);
      if (!exp_stall) begin
         hent_t e;
         m_look += NS;
         if (dv) begin
            e = '{0, seq_n, d, pool_m[0], map_m[d]};
            map_m[d] = pool_m.pop_front();
            m_dst++;
         end else begin
            e = '{1, seq_n, 0, 0, 0};
            m_ph++;
         end
         hist_m.push_back(e);
      end
      seq_n++;
      @(negedge clk);
      req_valid = 1'b0;
      req_dst_valid = 1'b0;
   endtask

   task automatic do_commit(input int dseq, input bit with_flush, input int sseq);
      commit_valid = 1'b1;
      commit_seq   = SW'(dseq);
      if (with_flush) begin
         squash_valid = 1'b1;
         squash_seq   = SW'(sseq);
      end
      @(posedge clk);
      @(negedge clk);
      commit_valid = 1'b0;
      squash_valid = 1'b0;
      if (!with_flush) begin
         while (hist_m.size() > 0 && hist_m[0].seq <= dseq) begin
            hent_t e = hist_m.pop_front();
            if (e.ph == 0) begin pool_m.push_back(e.pprev); m_com++; end
         end
      end
      repeat (HBD + 2) @(negedge clk);
   endtask

   // the model side of a flush; returns the number of entries removed
   function automatic int model_flush(input int sseq);
      int k = 0;
      while (hist_m.size() > 0 && hist_m[hist_m.size()-1].seq > sseq) begin
         hent_t e = hist_m.pop_back();
         m_und++;
         k++;
         if (e.ph == 0) begin
            map_m[e.arch] = e.pprev;
            pool_m.push_back(e.pnew);
            m_live++;
         end
      end
      return k;
   endfunction

   task automatic do_squash(input int sseq);
      int k, n;
      squash_valid = 1'b1;
      squash_seq   = SW'(sseq);
      #1;
      chk("R6 stall in flush cycle", int'(stall), 1);
      @(posedge clk);
      @(negedge clk);
      squash_valid = 1'b0;
      k = model_flush(sseq);
      n = 0;
      #1;
      while (stall && n < 4 * HBD) begin
         n++;
         @(negedge clk);
         #1;
      end
      chk("R6 unwind stall length", n, k + 1);
      @(negedge clk);
   endtask

   task automatic check_map(input string req);
      for (int a = 0; a < NA; a += 2) begin
         req_src_arch = {AW'(a + 1), AW'(a)};
         #1;
         chk(req, src_of(0), map_m[a]);
         chk(req, src_of(1), map_m[a + 1]);
         @(negedge clk);
      end
   endtask

   task automatic check_counters();
      chk("R10 dst renames", int'(c_dst), m_dst);
      chk("R10 src lookups", int'(c_look), m_look);
      chk("R10 placeholders", int'(c_ph), m_ph);
      chk("R10 committed maps", int'(c_com), m_com);
      chk("R10 undone maps", int'(c_und), m_und);
      chk("R10 undone live maps", int'(c_live), m_live);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      int cnt_before, first_seq;
      void'($urandom(32'd4077));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 stall idle", int'(stall), 0);
      chk("R1 pool head", int'(dst_phys_new), NA);
      check_counters();
      check_map("R1 identity map");

      // R3, R2: a dependent chain
      do_rename(1, 2, 1'b1, 3);
      do_rename(3, 3, 1'b1, 3);
      do_rename(3, 0, 1'b1, 5);
      // R4: placeholder leaves map and pool alone
      cnt_before = pool_m.size();
      do_rename(3, 5, 1'b0, 7);
      chk("R4 pool head unchanged", int'(dst_phys_new), pool_m[0]);
      chk("R4 pool size model", pool_m.size(), cnt_before);
      check_map("R4 map after placeholder");

      // R8: drain the pool, then destinations stall but placeholders pass
      while (pool_m.size() > 0) do_rename(0, 1, 1'b1, int'($urandom % NA));
      do_rename(2, 4, 1'b1, 9);
      do_rename(2, 4, 1'b0, 0);
      // R9: fill the history with placeholders, then everything stalls
      while (hist_m.size() < HBD) do_rename(6, 7, 1'b0, 0);
      do_rename(1, 1, 1'b0, 0);
      do_rename(1, 1, 1'b1, 2);
      check_counters();

      // R6: completion in the flush cycle is ignored
      first_seq = hist_m[0].seq;
      cnt_before = m_com;
      do_commit(first_seq + 3, 1'b1, hist_m[hist_m.size()-1].seq - 2);
      void'(model_flush(hist_m[hist_m.size()-1].seq - 2));
      chk("R6 completion ignored during flush", int'(c_com), cnt_before);
      check_counters();

      // R7: partial completion then pool order
      do_commit(first_seq + 3, 1'b0, 0);
      check_counters();
      do_rename(0, 3, 1'b1, 11);
      check_map("R7 map after completion");

      // R5: flush a middle slice, then everything
      do_squash(hist_m[hist_m.size() / 2].seq);
      check_map("R5 map after partial flush");
      do_squash(0);
      check_map("R5 map after full flush");
      check_counters();

      // randomized mix
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom % 10);
         if (op < 6 || hist_m.size() == 0) begin
            do_rename(int'($urandom % NA), int'($urandom % NA),
                      1'(($urandom % 4) != 0), int'($urandom % NA));
         end else if (op < 8) begin
            int idx = int'($urandom % hist_m.size());
            do_commit(hist_m[idx].seq, 1'b0, 0);
         end else begin
            int idx = int'($urandom % hist_m.size());
            do_squash((($urandom % 4) == 0) ? hist_m[0].seq - 1 : hist_m[idx].seq);
         end
         if (it % 50 == 49) begin
            check_counters();
            check_map("R5 map during random mix");
         end
      end
      check_counters();
      check_map("R3 final map");
      finish_run();
   end

endmodule